// File: doc/BRIEF.md
# Word-Interleaved Multibank Cache Router

This block sits between up to four memory requesters and four data cache banks. Each cycle every requester may present one read or write with a byte address. The router looks the address up in one shared set-associative tag store, picks the target bank from the word address, and forwards the request to that bank. When two or more hitting requests want the same bank in the same cycle, a rotating-priority arbiter in that bank picks one. The others receive a retry and must hold their request. A read response comes back from the bank one cycle after the grant and is steered to the requester that issued it.

Lines are placed and removed through a single maintenance port. An accepted allocate or invalidate updates the shared tag store once and is broadcast to every bank with the same set, way and operation. It stays pending at each bank until that bank acknowledges, so no bank can hold a line that another lacks. While a maintenance request is presented or any bank has not yet acknowledged, no access is granted.

Top module: `wi_bank_router`

## Requirements
- R1: The target bank is byte address bits [3:2]. Bits [1:0] play no part in routing. A forwarded request appears on the bank output equal to that index, carrying the full byte address.
- R2: With default line size, the set index is taken from the address bits just above the 6-bit line offset, and the tag from the bits above the set index. A request whose set holds no valid way with a matching tag raises `req_miss` in the same cycle and is not forwarded to any bank.
- R3: Each bank grants at most one request per cycle. Of several hitting requests to one bank, exactly one gets `req_ready`. The others get `req_retry` in the same cycle.
- R4: Each bank serves its requesters in rotating order. After reset it searches from port 0. After a grant to port k it searches from port k+1, wrapping to port 0 after the last port.
- R5: A read granted in one cycle returns the bank's read data on `rsp_valid`/`rsp_rdata` of the same requester in the next cycle.
- R6: The cycle after a maintenance request is accepted, `bk_mnt_valid` is high on every bank, with one shared operation (`bk_mnt_inval` 0 = allocate, 1 = invalidate), set and way. Each bank's line stays high until that bank acknowledges.
- R7: While `mnt_valid` is high or any `bk_mnt_valid` bit is high, no bank request is issued. Hitting requests get `req_retry`.
- R8: `mnt_ready` is low while any bank has not yet acknowledged the current broadcast.
- R9: After an invalidate of a set and way is accepted, a request to that line misses.
- R10: When the chosen bank has `bk_ready` low, the request stays on the bank output, the requester gets `req_retry`, and no grant is made.
- R11: A write is forwarded with `bk_we` high and its write data on `bk_wdata`.
- R12: `bk_way` carries the way in which the forwarded request hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Request present, per requester |
| req_we | input | NUM_PORTS | 1 = write, 0 = read |
| req_addr | input | NUM_PORTS x ADDR_W | Byte address per requester |
| req_wdata | input | NUM_PORTS x DATA_W | Write data per requester |
| req_ready | output | NUM_PORTS | Request granted this cycle |
| req_retry | output | NUM_PORTS | Request not taken; hold and retry |
| req_miss | output | NUM_PORTS | Request missed the shared tags |
| rsp_valid | output | NUM_PORTS | Read data returned |
| rsp_rdata | output | NUM_PORTS x DATA_W | Returned read data |
| bk_valid | output | NUM_BANKS | Request to bank |
| bk_we | output | NUM_BANKS | Write flag to bank |
| bk_addr | output | NUM_BANKS x ADDR_W | Byte address to bank |
| bk_wdata | output | NUM_BANKS x DATA_W | Write data to bank |
| bk_way | output | NUM_BANKS x WAY_W | Way that hit |
| bk_ready | input | NUM_BANKS | Bank can take a request |
| bk_rsp_valid | input | NUM_BANKS | Bank read data valid |
| bk_rsp_rdata | input | NUM_BANKS x DATA_W | Bank read data |
| mnt_valid | input | 1 | Maintenance request present |
| mnt_ready | output | 1 | Maintenance request accepted |
| mnt_inval | input | 1 | 0 = allocate, 1 = invalidate |
| mnt_addr | input | ADDR_W | Byte address of the line |
| mnt_way | input | WAY_W | Way to allocate or invalidate |
| bk_mnt_valid | output | NUM_BANKS | Broadcast pending per bank |
| bk_mnt_ack | input | NUM_BANKS | Bank has applied the broadcast |
| bk_mnt_inval | output | 1 | Broadcast operation |
| bk_mnt_set | output | SET_W | Broadcast set index |
| bk_mnt_way | output | WAY_W | Broadcast way |

## Verification
The bench keeps four requesters and four banks but shrinks each bank to 128 bytes. That leaves eight 64-byte lines in two sets, so set index bit 6 and the tag above it both matter. Misses on the set index and misses on the tag can be produced with only a handful of allocated lines. With four ports on four banks, every collision pattern is reachable, including the wrap-around of the rotating pointer. Bank acknowledge delays are set separately per bank, which opens up a broadcast that stays pending at one bank while the others have finished.

// File: rtl/wi_router_pkg.sv
package wi_router_pkg;
    typedef enum logic {
        OP_ALLOC = 1'b0,
        OP_INVAL = 1'b1
    } line_op_e;
endpackage

// File: rtl/wi_tag_store.sv
module wi_tag_store #(
    parameter int NUM_PORTS = 4,
    parameter int SETS      = 256,
    parameter int WAYS      = 4,
    parameter int SET_W     = 8,
    parameter int TAG_W     = 18,
    parameter int WAY_W     = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS-1:0][SET_W-1:0]   lk_set,
    input  logic [NUM_PORTS-1:0][TAG_W-1:0]   lk_tag,
    output logic [NUM_PORTS-1:0]              lk_hit,
    output logic [NUM_PORTS-1:0][WAY_W-1:0]   lk_way,
    input  logic                              upd_en,
    input  wi_router_pkg::line_op_e           upd_op,
    input  logic [SET_W-1:0]                  upd_set,
    input  logic [TAG_W-1:0]                  upd_tag,
    input  logic [WAY_W-1:0]                  upd_way
);
    import wi_router_pkg::*;

    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  vld_d [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_d [SETS][WAYS];

    always_comb begin
        vld_d = vld_q;
        tag_d = tag_q;
        if (upd_en) begin
            vld_d[upd_set][upd_way] = (upd_op == OP_ALLOC);
            if (upd_op == OP_ALLOC) begin
                tag_d[upd_set][upd_way] = upd_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q <= tag_d;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_look
        logic             hit_l;
        logic [WAY_W-1:0] way_l;
        always_comb begin
            hit_l = 1'b0;
            way_l = '0;
            for (int w = 0; w < WAYS; w++) begin
                if (vld_q[lk_set[p]][w] && tag_q[lk_set[p]][w] == lk_tag[p]) begin
                    hit_l = 1'b1;
                    way_l = WAY_W'(w);
                end
            end
        end
        assign lk_hit[p] = hit_l;
        assign lk_way[p] = way_l;
    end
endmodule

// File: rtl/wi_rr_arb.sv
module wi_rr_arb #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] cand,
    input  logic                 take,
    output logic                 win_valid,
    output logic [PORT_W-1:0]    win_idx,
    output logic [NUM_PORTS-1:0] gnt,
    output logic [PORT_W-1:0]    own_q
);
    logic [PORT_W-1:0] ptr_q, ptr_d, own_d;

    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int k = 0; k < NUM_PORTS; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % NUM_PORTS;
            if (!win_valid && cand[idx]) begin
                win_valid = 1'b1;
                win_idx   = PORT_W'(idx);
            end
        end
        gnt   = '0;
        ptr_d = ptr_q;
        own_d = own_q;
        if (win_valid && take) begin
            gnt[win_idx] = 1'b1;
            ptr_d = (int'(win_idx) == NUM_PORTS - 1) ? '0 : win_idx + 1'b1;
            own_d = win_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            own_q <= '0;
        end else begin
            ptr_q <= ptr_d;
            own_q <= own_d;
        end
    end

    assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R4: the grant always goes to a port that asked
    assert_grant_from_cand_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~cand) == '0);
endmodule

// File: rtl/wi_mnt_seq.sv
module wi_mnt_seq #(
    parameter int NUM_BANKS = 4,
    parameter int FIELD_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mnt_valid,
    input  logic [FIELD_W-1:0]   mnt_fields,
    output logic                 mnt_ready,
    output logic                 accept,
    output logic                 stall,
    input  logic [NUM_BANKS-1:0] bk_ack,
    output logic [NUM_BANKS-1:0] pend_q,
    output logic [FIELD_W-1:0]   fields_q
);
    logic [NUM_BANKS-1:0] pend_d;
    logic [FIELD_W-1:0]   fields_d;

    always_comb begin
        mnt_ready = (pend_q == '0);
        accept    = mnt_valid && mnt_ready;
        stall     = mnt_valid || (pend_q != '0);
        pend_d    = pend_q & ~bk_ack;
        fields_d  = fields_q;
        if (accept) begin
            pend_d   = '1;
            fields_d = mnt_fields;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            fields_q <= '0;
        end else begin
            pend_q   <= pend_d;
            fields_q <= fields_d;
        end
    end

    assert_pend_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) |=> ((pend_q & ~$past(bk_ack)) == ($past(pend_q) & ~$past(bk_ack))));
endmodule

// File: rtl/wi_bank_router.sv
module wi_bank_router #(
    parameter int NUM_PORTS  = 4,
    parameter int NUM_BANKS  = 4,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int BANK_BYTES = 16384,
    parameter int LINE_BYTES = 64,
    parameter int WAYS       = 4,
    localparam int WAY_W     = $clog2(WAYS),
    localparam int PORT_W    = $clog2(NUM_PORTS),
    localparam int BANK_W    = $clog2(NUM_BANKS),
    localparam int BANK_LSB  = $clog2(DATA_W / 8),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int SETS      = (NUM_BANKS * BANK_BYTES / LINE_BYTES) / WAYS,
    localparam int SET_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - OFF_W - SET_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_PORTS-1:0]               req_valid,
    input  logic [NUM_PORTS-1:0]               req_we,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]   req_addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]   req_wdata,
    output logic [NUM_PORTS-1:0]               req_ready,
    output logic [NUM_PORTS-1:0]               req_retry,
    output logic [NUM_PORTS-1:0]               req_miss,
    output logic [NUM_PORTS-1:0]               rsp_valid,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]   rsp_rdata,
    output logic [NUM_BANKS-1:0]               bk_valid,
    output logic [NUM_BANKS-1:0]               bk_we,
    output logic [NUM_BANKS-1:0][ADDR_W-1:0]   bk_addr,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]   bk_wdata,
    output logic [NUM_BANKS-1:0][WAY_W-1:0]    bk_way,
    input  logic [NUM_BANKS-1:0]               bk_ready,
    input  logic [NUM_BANKS-1:0]               bk_rsp_valid,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]   bk_rsp_rdata,
    input  logic                               mnt_valid,
    output logic                               mnt_ready,
    input  logic                               mnt_inval,
    input  logic [ADDR_W-1:0]                  mnt_addr,
    input  logic [WAY_W-1:0]                   mnt_way,
    output logic [NUM_BANKS-1:0]               bk_mnt_valid,
    input  logic [NUM_BANKS-1:0]               bk_mnt_ack,
    output logic                               bk_mnt_inval,
    output logic [SET_W-1:0]                   bk_mnt_set,
    output logic [WAY_W-1:0]                   bk_mnt_way
);
    import wi_router_pkg::*;

    localparam int FIELD_W = 1 + SET_W + WAY_W;

    logic [NUM_PORTS-1:0][SET_W-1:0]  port_set;
    logic [NUM_PORTS-1:0][TAG_W-1:0]  port_tag;
    logic [NUM_PORTS-1:0][BANK_W-1:0] port_bank;
    logic [NUM_PORTS-1:0]             hit;
    logic [NUM_PORTS-1:0][WAY_W-1:0]  hit_way;

    logic                             accept, stall;
    logic [FIELD_W-1:0]               mnt_fields, fields_q;

    logic [NUM_BANKS-1:0][NUM_PORTS-1:0] cand, gnt;
    logic [NUM_BANKS-1:0]                win_valid;
    logic [NUM_BANKS-1:0][PORT_W-1:0]    win_idx, own;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign port_set[p]  = req_addr[p][OFF_W +: SET_W];
        assign port_tag[p]  = req_addr[p][OFF_W + SET_W +: TAG_W];
        assign port_bank[p] = req_addr[p][BANK_LSB +: BANK_W];
    end

    wi_tag_store #(
        .NUM_PORTS(NUM_PORTS), .SETS(SETS), .WAYS(WAYS),
        .SET_W(SET_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_set(port_set), .lk_tag(port_tag),
        .lk_hit(hit), .lk_way(hit_way),
        .upd_en(accept),
        .upd_op(mnt_inval ? OP_INVAL : OP_ALLOC),
        .upd_set(mnt_addr[OFF_W +: SET_W]),
        .upd_tag(mnt_addr[OFF_W + SET_W +: TAG_W]),
        .upd_way(mnt_way)
    );

    assign mnt_fields = {mnt_inval, mnt_addr[OFF_W +: SET_W], mnt_way};

    wi_mnt_seq #(.NUM_BANKS(NUM_BANKS), .FIELD_W(FIELD_W)) u_mnt (
        .clk(clk), .rst_n(rst_n),
        .mnt_valid(mnt_valid), .mnt_fields(mnt_fields),
        .mnt_ready(mnt_ready), .accept(accept), .stall(stall),
        .bk_ack(bk_mnt_ack), .pend_q(bk_mnt_valid), .fields_q(fields_q)
    );

    assign {bk_mnt_inval, bk_mnt_set, bk_mnt_way} = fields_q;

    always_comb begin
        cand = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_valid[p] && hit[p] && !stall) cand[port_bank[p]][p] = 1'b1;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        wi_rr_arb #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_arb (
            .clk(clk), .rst_n(rst_n),
            .cand(cand[b]), .take(bk_ready[b]),
            .win_valid(win_valid[b]), .win_idx(win_idx[b]),
            .gnt(gnt[b]), .own_q(own[b])
        );
        assign bk_valid[b] = win_valid[b];
        assign bk_we[b]    = req_we[win_idx[b]];
        assign bk_addr[b]  = req_addr[win_idx[b]];
        assign bk_wdata[b] = req_wdata[win_idx[b]];
        assign bk_way[b]   = hit_way[win_idx[b]];

        assert_bank_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
            bk_valid[b] |-> (int'(bk_addr[b][BANK_LSB +: BANK_W]) == b));
    end

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            logic rdy;
            rdy = 1'b0;
            for (int b = 0; b < NUM_BANKS; b++) rdy = rdy | gnt[b][p];
            req_ready[p] = rdy;
            req_miss[p]  = req_valid[p] && !hit[p] && !stall;
            req_retry[p] = req_valid[p] && !rdy && !(req_valid[p] && !hit[p] && !stall);
            rsp_valid[p] = 1'b0;
            rsp_rdata[p] = '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bk_rsp_valid[b] && own[b] == PORT_W'(p)) begin
                    rsp_valid[p] = 1'b1;
                    rsp_rdata[p] = bk_rsp_rdata[b];
                end
            end
        end
    end

    assert_no_grant_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_mnt_valid != '0) |-> (bk_valid == '0));

    assert_lockstep_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((bk_mnt_valid != '0) && ($past(bk_mnt_valid) == '0)) |-> (bk_mnt_valid == '1));

    assert_mnt_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_mnt_valid != '0) |-> !mnt_ready);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        assert_rsp_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[p] |-> $past(req_ready[p] && !req_we[p]));
    end
endmodule

// File: tb/wi_bank_router_test.sv
module wi_bank_router_test;
    localparam int NP = 4, NB = 4, AW = 32, DW = 32, WW = 2;
    localparam logic [31:0] KEY = 32'h5A5A_0000;

    typedef struct packed {
        logic [3:0]       v;
        logic [3:0][31:0] a;
        logic [3:0]       rdy;
        logic [3:0]       rty;
        logic [3:0]       mis;
    } vec_t;

    // address order in each entry: port3, port2, port1, port0
    localparam vec_t VECS [6] = '{
        '{4'b1111, {32'h0F, 32'h88, 32'h44, 32'h00}, 4'b1111, 4'b0000, 4'b0000},
        '{4'b1111, {32'h30, 32'h20, 32'h10, 32'h00}, 4'b0010, 4'b1101, 4'b0000},
        '{4'b1111, {32'h30, 32'h20, 32'h10, 32'h00}, 4'b0100, 4'b1011, 4'b0000},
        '{4'b0011, {32'h30, 32'h20, 32'h10, 32'h00}, 4'b0001, 4'b0010, 4'b0000},
        '{4'b0111, {32'h00, 32'h1C0, 32'h14, 32'h100}, 4'b0010, 4'b0000, 4'b0101},
        '{4'b1100, {32'h54, 32'h44, 32'h00, 32'h00}, 4'b0100, 4'b1000, 4'b0000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NP-1:0] req_valid = '0, req_we = '0, req_ready, req_retry, req_miss, rsp_valid;
    logic [NP-1:0][AW-1:0] req_addr = '0;
    logic [NP-1:0][DW-1:0] req_wdata = '0, rsp_rdata;
    logic [NB-1:0] bk_valid, bk_we, bk_ready = '1, bk_rsp_valid, bk_mnt_valid, bk_mnt_ack;
    logic [NB-1:0][AW-1:0] bk_addr;
    logic [NB-1:0][DW-1:0] bk_wdata, bk_rsp_rdata;
    logic [NB-1:0][WW-1:0] bk_way;
    logic mnt_valid = 1'b0, mnt_ready, mnt_inval = 1'b0, bk_mnt_inval;
    logic [AW-1:0] mnt_addr = '0;
    logic [WW-1:0] mnt_way = '0, bk_mnt_way;
    logic bk_mnt_set;
    int   ack_dly [NB];
    int   ack_cnt [NB];
    int   n_run = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    wi_bank_router #(.BANK_BYTES(128)) uut (.*);

    // behavioural banks: one cycle to read data, per-bank acknowledge delay
    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (!rst_n) begin
                bk_rsp_valid[b] <= 1'b0;
                bk_rsp_rdata[b] <= '0;
                ack_cnt[b] <= 0;
            end else begin
                bk_rsp_valid[b] <= bk_valid[b] && bk_ready[b] && !bk_we[b];
                bk_rsp_rdata[b] <= bk_addr[b] ^ KEY;
                ack_cnt[b] <= (!bk_mnt_valid[b] || bk_mnt_ack[b]) ? 0 : ack_cnt[b] + 1;
            end
        end
    end

    always_comb begin
        for (int b = 0; b < NB; b++) bk_mnt_ack[b] = bk_mnt_valid[b] && (ack_cnt[b] >= ack_dly[b]);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic mnt_issue(input logic inval, input logic [31:0] addr, input logic [1:0] way);
        @(negedge clk);
        mnt_valid = 1'b1; mnt_inval = inval; mnt_addr = addr; mnt_way = way;
        @(negedge clk);
        mnt_valid = 1'b0;
    endtask

    task automatic mnt_wait();
        while (bk_mnt_valid != '0) @(negedge clk);
    endtask

    initial begin
        while (cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) ack_dly[b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state
        chk(mnt_ready == 1'b1, "R8 reset mnt_ready", 32'(mnt_ready), 32'h1);
        chk(bk_valid == '0 && bk_mnt_valid == '0, "R6 reset bank lines", {bk_valid, bk_mnt_valid}, 32'h0);
        chk(rsp_valid == '0 && req_ready == '0, "R5 reset outputs", {rsp_valid, req_ready}, 32'h0);

        // allocate three lines: 0x00 way0, 0x40 way1, 0x80 way2
        mnt_issue(1'b0, 32'h00, 2'd0);
        #1;
        chk(bk_mnt_valid == 4'b1111, "R6 broadcast to all banks", 32'(bk_mnt_valid), 32'hF);
        chk({bk_mnt_inval, bk_mnt_set, bk_mnt_way} == 4'b0000, "R6 broadcast fields",
            32'({bk_mnt_inval, bk_mnt_set, bk_mnt_way}), 32'h0);
        mnt_wait();
        mnt_issue(1'b0, 32'h40, 2'd1); mnt_wait();
        mnt_issue(1'b0, 32'h80, 2'd2); mnt_wait();

        // table of collision and miss patterns
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            req_valid = VECS[i].v;
            req_addr  = VECS[i].a;
            #1;
            chk(req_ready == VECS[i].rdy, $sformatf("R3 R4 vec%0d ready", i), 32'(req_ready), 32'(VECS[i].rdy));
            chk(req_retry == VECS[i].rty, $sformatf("R3 vec%0d retry", i), 32'(req_retry), 32'(VECS[i].rty));
            chk(req_miss == VECS[i].mis, $sformatf("R2 vec%0d miss", i), 32'(req_miss), 32'(VECS[i].mis));
            if (i == 0) chk(bk_addr[3] == 32'h0F, "R1 low bits kept, bank3", bk_addr[3], 32'h0F);
        end
        @(negedge clk);
        req_valid = '0;

        // delayed acknowledge at bank 2: allocate 0xC0 in way3
        ack_dly[2] = 2;
        mnt_issue(1'b0, 32'hC0, 2'd3);
        #1;
        chk({bk_mnt_set, bk_mnt_way} == 3'b111, "R6 set and way", 32'({bk_mnt_set, bk_mnt_way}), 32'h7);
        @(negedge clk);
        req_valid[0] = 1'b1; req_addr[0] = 32'h00;
        #1;
        chk(bk_mnt_valid == 4'b0100, "R6 slow bank still pending", 32'(bk_mnt_valid), 32'h4);
        chk(mnt_ready == 1'b0, "R8 busy during broadcast", 32'(mnt_ready), 32'h0);
        chk(req_retry[0] && !req_ready[0] && bk_valid == '0, "R7 grant withheld",
            {req_retry, req_ready, bk_valid}, {4'b0001, 4'b0000, 4'b0000});
        @(negedge clk);
        #1;
        chk(req_retry[0] == 1'b1, "R7 withheld until ack", 32'(req_retry), 32'h1);
        @(negedge clk);
        #1;
        chk(req_ready[0] == 1'b1 && bk_mnt_valid == '0, "R7 grant after ack", {req_ready, bk_mnt_valid}, 32'h10);
        ack_dly[2] = 0;
        @(negedge clk);
        req_valid = '0;
        #1;
        chk(rsp_valid == 4'b0001, "R5 response port", 32'(rsp_valid), 32'h1);
        chk(rsp_rdata[0] == (32'h00 ^ KEY), "R5 response data", rsp_rdata[0], KEY);

        // second read on a different bank and port
        req_valid[3] = 1'b1; req_addr[3] = 32'h48;
        #1;
        chk(bk_valid[2] && bk_addr[2] == 32'h48, "R1 bank2 route", bk_addr[2], 32'h48);
        @(negedge clk);
        req_valid = '0;
        #1;
        chk(rsp_valid[3] && rsp_rdata[3] == (32'h48 ^ KEY), "R5 port3 data", rsp_rdata[3], 32'h48 ^ KEY);

        // hit way on the bank output
        req_valid = 4'b0110; req_addr[2] = 32'h88; req_addr[1] = 32'hC4;
        #1;
        chk(bk_way[2] == 2'd2, "R12 way of 0x88", 32'(bk_way[2]), 32'h2);
        chk(bk_way[1] == 2'd3, "R12 way of 0xC4", 32'(bk_way[1]), 32'h3);
        @(negedge clk);
        req_valid = '0;

        // write forwarding
        req_valid[1] = 1'b1; req_we[1] = 1'b1; req_addr[1] = 32'h04; req_wdata[1] = 32'hDEADBEEF;
        #1;
        chk(bk_valid[1] && bk_we[1] && req_ready[1], "R11 write forwarded", {bk_valid, bk_we, req_ready}, 32'h222);
        chk(bk_wdata[1] == 32'hDEADBEEF, "R11 write data", bk_wdata[1], 32'hDEADBEEF);
        @(negedge clk);
        req_valid = '0; req_we = '0;

        // bank not ready
        bk_ready[3] = 1'b0;
        req_valid[3] = 1'b1; req_addr[3] = 32'h0C;
        #1;
        chk(bk_valid[3] && req_retry[3] && !req_ready[3], "R10 bank busy", {bk_valid, req_retry, req_ready}, 32'h880);
        @(negedge clk);
        bk_ready[3] = 1'b1;
        #1;
        chk(req_ready[3] == 1'b1, "R10 grant once ready", 32'(req_ready), 32'h8);
        @(negedge clk);
        req_valid = '0;

        // invalidate line 0x00 way0, then access misses
        mnt_issue(1'b1, 32'h00, 2'd0);
        #1;
        chk(bk_mnt_inval == 1'b1 && bk_mnt_valid == 4'b1111, "R6 invalidate broadcast",
            {bk_mnt_inval, bk_mnt_valid}, 32'h1F);
        mnt_wait();
        req_valid[0] = 1'b1; req_addr[0] = 32'h00;
        #1;
        chk(req_miss[0] && !req_ready[0] && !bk_valid[0], "R9 invalidated line misses",
            {req_miss, req_ready, bk_valid}, 32'h100);
        @(negedge clk);
        req_valid = '0;
        #1;
        chk(rsp_valid == '0, "R2 miss gives no response", 32'(rsp_valid), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule